// File: doc/BRIEF.md
# Dual-Thread Low-Power State Sequencer

This block tracks the power state of a processor core that runs two logical threads. There are four states: Normal, HALT, Stop-Grant and Sleep. The core reports which threads have halted. System logic drives a stop-clock request, a sleep request, wake events and bus-initialisation events. From these inputs the sequencer decides the current state. It also decides whether the core may accept snoops and interrupts.

The block defers a bus-initialisation event that arrives while clocks are stopped. Once the core leaves the stopped states, the event shows as a pending flag. The block watches for illegal input activity while in Sleep and flags it. It steers one shared output pin: the pin carries a floating-point error or a pending break event, depending on the stop-clock request. Configuration straps are captured at the end of reset and then held.

Top module: `lps_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `state_o`=00 (Normal), `binit_pend`=0, `proto_viol`=0 and `snoop_en`=1. The state code is 00 Normal, 01 HALT, 10 Stop-Grant, 11 Sleep.
- R2: From Normal with the stop-clock request low, the block moves to HALT on the next edge only when every bit of `halt_req` is set. With only some bits set it stays in Normal.
- R3: In HALT with the stop-clock request low, the block returns to Normal on the next edge if `wake_evt` is high or any `halt_req` bit is clear.
- R4: From Normal or HALT, a high `stpclk_req` moves the block to Stop-Grant on the next edge. This takes priority over `wake_evt` and `halt_req`.
- R5: In Stop-Grant, dropping `stpclk_req` returns the block to the state it held just before entering Stop-Grant (Normal or HALT).
- R6: A `binit_evt` sampled in Stop-Grant is latched. `binit_pend` stays low while in Stop-Grant or Sleep, goes high once the block is in Normal or HALT, and holds until reset. A `binit_evt` seen in Normal or HALT does not set it.
- R7: In Stop-Grant, a high `sleep_req` with `stpclk_req` still high enters Sleep. In Sleep, a low `sleep_req` returns to Stop-Grant. Sleep ignores `stpclk_req` and `wake_evt`. `snoop_en` is low only in Sleep.
- R8: In Sleep, any change of `stpclk_req`, `wake_evt`, `binit_evt` or `halt_req` between two edges sets `proto_viol` after the second edge. The flag stays set until reset. With no such change it stays low.
- R9: `err_pbe` equals `brk_evt` while `stpclk_req` is high and `fp_err` while it is low, with no clock delay.
- R10: `cfg_q` equals the `cfg_in` value at the last edge where `rst` was high. After that it does not change while `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | THREADS | One bit per thread: the thread has halted |
| wake_evt | input | 1 | Interrupt or other wake event |
| stpclk_req | input | 1 | Stop-clock request |
| sleep_req | input | 1 | Sleep request |
| binit_evt | input | 1 | Bus-initialisation event |
| fp_err | input | 1 | Floating-point error indication |
| brk_evt | input | 1 | Pending break event indication |
| cfg_in | input | CFG_W | Configuration straps |
| state_o | output | 2 | Current power state code |
| snoop_en | output | 1 | Snoops and interrupts may be accepted |
| binit_pend | output | 1 | Deferred bus-initialisation pending |
| err_pbe | output | 1 | Shared error / break-event output |
| proto_viol | output | 1 | Illegal input change seen in Sleep |
| cfg_q | output | CFG_W | Configuration sampled at reset release |

## Verification
The bench targets these corner cases:
- A partial halt mask. A design that ORs the mask instead of ANDing it drops into HALT with one thread still running.
- A wake event and a stop-clock request arriving on the same edge. A design with the wrong priority returns to Normal instead of Stop-Grant.
- Leaving Stop-Grant after entering it from HALT. A design that always returns to Normal shows up here.
- A bus-initialisation event inside Stop-Grant. The bench checks that the pending flag appears only after exit, and that the same event in Normal never raises it.
- Inputs toggled inside Sleep. The state must not move, and the violation flag must rise and stay set until reset.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        PS_NORMAL    = 2'b00,
        PS_HALT      = 2'b01,
        PS_STOPGRANT = 2'b10,
        PS_SLEEP     = 2'b11
    } pstate_e;

    // Clocks stopped: a deferred event must stay hidden in these states.
    function automatic logic is_quiesced(pstate_e s);
        return (s == PS_STOPGRANT) || (s == PS_SLEEP);
    endfunction

    // States that Stop-Grant may return to.
    function automatic logic is_running(pstate_e s);
        return (s == PS_NORMAL) || (s == PS_HALT);
    endfunction

endpackage

// File: rtl/lps_state_seq.sv
module lps_state_seq
    import lps_pkg::*;
#(
    parameter int THREADS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THREADS-1:0] halt_req,
    input  logic               wake_evt,
    input  logic               stpclk_req,
    input  logic               sleep_req,
    output pstate_e            state_o
);

    pstate_e state_q, state_d;
    pstate_e ret_q, ret_d;
    logic    all_halted;

    assign all_halted = &halt_req;

    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        unique case (state_q)
            PS_NORMAL: begin
                if (stpclk_req) begin
                    state_d = PS_STOPGRANT;
                    ret_d   = PS_NORMAL;
                end else if (all_halted) begin
                    state_d = PS_HALT;
                end
            end
            PS_HALT: begin
                if (stpclk_req) begin
                    state_d = PS_STOPGRANT;
                    ret_d   = PS_HALT;
                end else if (wake_evt || !all_halted) begin
                    state_d = PS_NORMAL;
                end
            end
            PS_STOPGRANT: begin
                if (!stpclk_req) begin
                    state_d = ret_q;
                end else if (sleep_req) begin
                    state_d = PS_SLEEP;
                end
            end
            PS_SLEEP: begin
                if (!sleep_req) begin
                    state_d = PS_STOPGRANT;
                end
            end
            default: state_d = PS_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_NORMAL;
            ret_q   <= PS_NORMAL;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    assign state_o = state_q;

    // R2: an incomplete halt mask never leads out of Normal into HALT
    p_partial_stays_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_NORMAL && !stpclk_req && !(&halt_req)) |=> (state_q == PS_NORMAL))
        else $error("R2 violated");

    // R4: stop-clock request from a running state reaches Stop-Grant
    p_stpclk_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (is_running(state_q) && stpclk_req) |=> (state_q == PS_STOPGRANT))
        else $error("R4 violated");

    // R7: Sleep is entered only from Stop-Grant
    p_sleep_only_from_sg_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_SLEEP && state_q != PS_STOPGRANT) |=> (state_q != PS_SLEEP))
        else $error("R7 entry violated");

    // R7: releasing sleep returns to Stop-Grant
    p_sleep_release_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_SLEEP && !sleep_req) |=> (state_q == PS_STOPGRANT))
        else $error("R7 release violated");

endmodule

// File: rtl/lps_init_latch.sv
module lps_init_latch
    import lps_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pstate_e state_i,
    input  logic    binit_evt,
    output logic    pend_o
);

    logic latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
        end else if (binit_evt && state_i == PS_STOPGRANT) begin
            latch_q <= 1'b1;
        end
    end

    assign pend_o = latch_q && !is_quiesced(state_i);

    // R6: an event seen during Stop-Grant is captured
    p_binit_capture_r6: assert property (@(posedge clk) disable iff (rst)
        (state_i == PS_STOPGRANT && binit_evt) |=> latch_q)
        else $error("R6 capture violated");

    // R6: once captured, the event is held until reset
    p_binit_hold_r6: assert property (@(posedge clk) disable iff (rst)
        latch_q |=> latch_q)
        else $error("R6 hold violated");

endmodule

// File: rtl/lps_sleep_guard.sv
module lps_sleep_guard
    import lps_pkg::*;
#(
    parameter int WATCH_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  pstate_e            state_i,
    input  logic [WATCH_W-1:0] watch_i,
    output logic               viol_o
);

    logic [WATCH_W-1:0] snap_q;
    logic               viol_q;
    logic               moved;

    assign moved = (watch_i != snap_q);

    always_ff @(posedge clk) begin
        snap_q <= watch_i;
        if (rst) begin
            viol_q <= 1'b0;
        end else if (state_i == PS_SLEEP && moved) begin
            viol_q <= 1'b1;
        end
    end

    assign viol_o = viol_q;

    // R8: the violation flag is sticky until reset
    p_viol_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        viol_q |=> viol_q)
        else $error("R8 violated");

endmodule

// File: rtl/lps_cfg_hold.sv
module lps_cfg_hold #(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_in,
    output logic [CFG_W-1:0] cfg_o
);

    logic [CFG_W-1:0] cfg_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r <= cfg_in;
        end
    end

    assign cfg_o = cfg_r;

    // R10: straps stay frozen outside reset
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg_r))
        else $error("R10 violated");

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
    import lps_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int CFG_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THREADS-1:0] halt_req,
    input  logic               wake_evt,
    input  logic               stpclk_req,
    input  logic               sleep_req,
    input  logic               binit_evt,
    input  logic               fp_err,
    input  logic               brk_evt,
    input  logic [CFG_W-1:0]   cfg_in,
    output logic [1:0]         state_o,
    output logic               snoop_en,
    output logic               binit_pend,
    output logic               err_pbe,
    output logic               proto_viol,
    output logic [CFG_W-1:0]   cfg_q
);

    localparam int WATCH_W = THREADS + 3;

    pstate_e            cur_state;
    logic [WATCH_W-1:0] watch_vec;

    lps_state_seq #(.THREADS(THREADS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .halt_req   (halt_req),
        .wake_evt   (wake_evt),
        .stpclk_req (stpclk_req),
        .sleep_req  (sleep_req),
        .state_o    (cur_state)
    );

    lps_init_latch u_binit (
        .clk       (clk),
        .rst       (rst),
        .state_i   (cur_state),
        .binit_evt (binit_evt),
        .pend_o    (binit_pend)
    );

    assign watch_vec = {halt_req, wake_evt, stpclk_req, binit_evt};

    lps_sleep_guard #(.WATCH_W(WATCH_W)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .state_i (cur_state),
        .watch_i (watch_vec),
        .viol_o  (proto_viol)
    );

    lps_cfg_hold #(.CFG_W(CFG_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .cfg_o  (cfg_q)
    );

    assign state_o  = cur_state;
    assign snoop_en = (cur_state != PS_SLEEP);
    assign err_pbe  = stpclk_req ? brk_evt : fp_err;

    // R5: leaving Stop-Grant always lands in a running state
    p_sg_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_state == PS_STOPGRANT && !stpclk_req) |=> is_running(cur_state))
        else $error("R5 violated");

endmodule

// File: tb/test_lps_ctrl.sv
module test_lps_ctrl;

    localparam int THREADS = 2;
    localparam int CFG_W   = 4;

    localparam logic [1:0] SN = 2'b00, SH = 2'b01, SG = 2'b10, SS = 2'b11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [THREADS-1:0] halt_req = '0;
    logic wake_evt = 1'b0, stpclk_req = 1'b0, sleep_req = 1'b0, binit_evt = 1'b0;
    logic fp_err = 1'b0, brk_evt = 1'b0;
    logic [CFG_W-1:0] cfg_in = 4'hA;
    logic [1:0] state_o;
    logic snoop_en, binit_pend, err_pbe, proto_viol;
    logic [CFG_W-1:0] cfg_q;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [1:0] st;
        logic       pend;
        logic       viol;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    lps_ctrl #(.THREADS(THREADS), .CFG_W(CFG_W)) i_lps_ctrl (
        .clk(clk), .rst(rst), .halt_req(halt_req), .wake_evt(wake_evt),
        .stpclk_req(stpclk_req), .sleep_req(sleep_req), .binit_evt(binit_evt),
        .fp_err(fp_err), .brk_evt(brk_evt), .cfg_in(cfg_in),
        .state_o(state_o), .snoop_en(snoop_en), .binit_pend(binit_pend),
        .err_pbe(err_pbe), .proto_viol(proto_viol), .cfg_q(cfg_q)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expectation per clock edge that has one queued
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " state"}, 32'(state_o), 32'(e.st));
            check({e.tag, " pend"},  32'(binit_pend), 32'(e.pend));
            check({e.tag, " viol"},  32'(proto_viol), 32'(e.viol));
            check({e.tag, " snoop"}, 32'(snoop_en), 32'(e.st != SS));
        end
    end

    // Driver: inputs are already set at a falling edge; queue the outcome
    task automatic step(logic [1:0] st, logic pend, logic viol, string tag);
        exp_t e;
        e.st = st; e.pend = pend; e.viol = viol; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(SN, 0, 0, "R1 reset");
        step(SN, 0, 0, "R1 reset");
        cfg_in = 4'h5;
        step(SN, 0, 0, "R1 reset last");
        rst = 1'b0; cfg_in = 4'h9;
        step(SN, 0, 0, "R1 after release");
        check("R10 cfg sampled", 32'(cfg_q), 32'h5);

        // R2: partial mask stays Normal, full mask halts
        halt_req = 2'b01;
        step(SN, 0, 0, "R2 partial");
        step(SN, 0, 0, "R2 partial hold");
        halt_req = 2'b11;
        step(SH, 0, 0, "R2 full");
        step(SH, 0, 0, "R2 stay");
        // R3: wake and halt-bit drop leave HALT
        wake_evt = 1'b1;
        step(SN, 0, 0, "R3 wake");
        wake_evt = 1'b0;
        step(SH, 0, 0, "R2 reenter");
        halt_req = 2'b10;
        step(SN, 0, 0, "R3 drop");
        halt_req = 2'b11;
        step(SH, 0, 0, "R2 again");
        // R4: stop-clock beats wake
        stpclk_req = 1'b1; wake_evt = 1'b1;
        step(SG, 0, 0, "R4 priority");
        wake_evt = 1'b0;
        step(SG, 0, 0, "R4 hold");
        // R6: deferred event hidden in Stop-Grant
        binit_evt = 1'b1;
        step(SG, 0, 0, "R6 hidden");
        binit_evt = 1'b0;
        step(SG, 0, 0, "R6 hidden hold");
        // R9 with stop-clock high
        fp_err = 1'b1; brk_evt = 1'b0; #0.5;
        check("R9 break path low", 32'(err_pbe), 32'(0));
        brk_evt = 1'b1; #0.5;
        check("R9 break path high", 32'(err_pbe), 32'(1));
        // R5: return to HALT, R6 now visible
        stpclk_req = 1'b0;
        #0.5;
        check("R9 error path", 32'(err_pbe), 32'(1));
        fp_err = 1'b0; #0.5;
        check("R9 error path low", 32'(err_pbe), 32'(0));
        brk_evt = 1'b0;
        @(negedge clk);
        step(SH, 1, 0, "R5 back to halt R6 visible");
        wake_evt = 1'b1;
        step(SN, 1, 0, "R3 wake R6 held");
        wake_evt = 1'b0; halt_req = 2'b00;
        step(SN, 1, 0, "R6 held");
        // R7: Sleep round trip without violation
        stpclk_req = 1'b1;
        step(SG, 0, 0, "R6 hidden again");
        sleep_req = 1'b1;
        step(SS, 0, 0, "R7 enter sleep");
        step(SS, 0, 0, "R8 quiet sleep");
        sleep_req = 1'b0;
        step(SG, 0, 0, "R7 release");
        stpclk_req = 1'b0;
        step(SN, 1, 0, "R5 back to normal");
        // R1: reset clears pending
        rst = 1'b1;
        step(SN, 0, 0, "R1 clears pend");
        rst = 1'b0;
        step(SN, 0, 0, "R1 after");
        check("R10 cfg resampled", 32'(cfg_q), 32'h9);
        cfg_in = 4'h3;
        // R6: event in Normal ignored
        binit_evt = 1'b1;
        step(SN, 0, 0, "R6 normal event");
        binit_evt = 1'b0;
        step(SN, 0, 0, "R6 normal ignored");
        check("R10 cfg frozen", 32'(cfg_q), 32'h9);
        // R8: wake toggled in Sleep
        stpclk_req = 1'b1;
        step(SG, 0, 0, "R8 setup");
        sleep_req = 1'b1;
        step(SS, 0, 0, "R8 in sleep");
        wake_evt = 1'b1;
        step(SS, 0, 1, "R8 wake flagged R7 ignored");
        wake_evt = 1'b0;
        step(SS, 0, 1, "R8 sticky");
        sleep_req = 1'b0;
        step(SG, 0, 1, "R8 sticky sg");
        stpclk_req = 1'b0;
        step(SN, 0, 1, "R8 sticky normal");
        rst = 1'b1;
        step(SN, 0, 0, "R1 clears viol");
        rst = 1'b0;
        step(SN, 0, 0, "R1 after viol");
        // R7/R8: stop-clock dropped in Sleep is ignored but flagged
        stpclk_req = 1'b1;
        step(SG, 0, 0, "R7 setup");
        sleep_req = 1'b1;
        step(SS, 0, 0, "R7 sleep");
        stpclk_req = 1'b0;
        step(SS, 0, 1, "R7 stpclk ignored R8 flagged");
        sleep_req = 1'b0;
        step(SG, 0, 1, "R7 release");
        step(SN, 0, 1, "R5 normal return");
        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule